// File: doc/BRIEF.md
# Per-Scanline Sprite Selector

This block runs once per video line. It walks a 64-entry table of sprite descriptors and picks at most eight whose 8-pixel-tall band covers the requested line. For each sprite it picks, it copies the fields the pixel pipeline needs into a small slot buffer. Each descriptor is one 32-bit word read through an asynchronous read port. Byte 0 (bits 7:0) is the top y coordinate, byte 1 is the tile number, byte 2 is the attribute byte and byte 3 is the x coordinate.

A start strobe captures the line number and a rotation index. The scan begins at the rotation index, examines one entry per clock and wraps modulo 64. When the software advances the rotation index on each frame, the sprites that miss out on a crowded line change from frame to frame. Those sprites flicker rather than vanish.

The scan always covers all 64 entries. When a ninth hit arrives it raises a sticky overflow flag. A one-cycle done pulse marks the end of the scan. The buffer then holds its contents until the next start.

Top module: `sprite_line_picker`

## Requirements
- R1: After reset, busy, done and overflow are 0 and the found count is 0.
- R2: An entry hits when the 9-bit difference line minus y (both 8-bit) lies in 0 to 7. A y greater than the line, or a difference of 8 or more, is a miss.
- R3: A hit that arrives while eight slots are already full is not stored and sets overflow. Overflow then stays set until the next start, and a start clears it to 0.
- R4: The found count never exceeds 8. Hits fill slots 0, 1, 2 and so on in the order the entries are examined.
- R5: A slot's row is the difference from R2. When attribute bit 7 (vertical flip) is set, the row is 7 minus that difference.
- R6: A slot holds the tile number, the x coordinate, the palette from attribute bits 1:0, behind-background from attribute bit 5 and horizontal flip from attribute bit 6.
- R7: After start, the read address steps through rot, rot+1, and so on modulo 64, one entry per clock, for 64 clocks.
- R8: done is a single-cycle pulse that appears one clock after the 64th entry is examined. busy is high for exactly those 64 clocks.
- R9: While idle with no start, the found count, overflow and all slots stay constant whatever the table and line inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a scan; restarts a scan in progress |
| line_i | input | 8 | Line to match; held during the scan |
| rot_i | input | 6 | First entry to examine |
| oam_addr_o | output | 6 | Entry index being read |
| oam_data_i | input | 32 | Descriptor word {x, attr, tile, y} |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle end-of-scan pulse |
| found_o | output | 4 | Slots filled |
| overflow_o | output | 1 | More than eight hits on this line |
| row_o | output | 24 | Per-slot row, 3 bits each, slot 0 in the low bits |
| tile_o | output | 64 | Per-slot tile number |
| x_o | output | 64 | Per-slot x coordinate |
| pal_o | output | 16 | Per-slot palette |
| behind_o | output | 8 | Per-slot behind-background bit |
| hflip_o | output | 8 | Per-slot horizontal flip |

## Verification
Overflow detection and the end of the scan can fall on the same clock edge. This happens when the ninth hit is the last entry in rotation order. To provoke it, eight hits are placed just after the rotation index and one more on the entry just before it. The check then requires that overflow was still 0 one cycle before done, and that overflow reads 1 in the same cycle that done first shows. A design that drops the hit on the final examined entry, or that ends the scan a cycle early, fails this check.

// File: rtl/spl_pkg.sv
package spl_pkg;
  localparam int COORD_W = 8;
  localparam int WORD_W  = 32;
  localparam int ATTR_BEHIND = 5;
  localparam int ATTR_HFLIP  = 6;
  localparam int ATTR_VFLIP  = 7;

  // signed-safe distance from sprite top to line, 9 bits so negatives stand out
  function automatic logic [8:0] spl_offset(logic [7:0] line, logic [7:0] y);
    return {1'b0, line} - {1'b0, y};
  endfunction

  function automatic logic spl_in_band(logic [8:0] off, int unsigned h);
    return off < 9'(h);
  endfunction

  function automatic logic [8:0] spl_row(logic [8:0] off, logic flip, int unsigned h);
    return flip ? (9'(h - 1) - off) : off;
  endfunction
endpackage

// File: rtl/spl_entry_eval.sv
module spl_entry_eval
  import spl_pkg::*;
#(
  parameter int SPR_H = 8,
  parameter int ROW_W = 3
) (
  input  logic [7:0]        line_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              in_band_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [7:0]        tile_o,
  output logic [7:0]        x_o,
  output logic [1:0]        pal_o,
  output logic              behind_o,
  output logic              hflip_o
);
  logic [7:0] y, attr;
  logic [8:0] off;

  always_comb begin
    y         = word_i[7:0];
    tile_o    = word_i[15:8];
    attr      = word_i[23:16];
    x_o       = word_i[31:24];
    off       = spl_offset(line_i, y);
    in_band_o = spl_in_band(off, SPR_H);
    row_o     = ROW_W'(spl_row(off, attr[ATTR_VFLIP], SPR_H));
    pal_o     = attr[1:0];
    behind_o  = attr[ATTR_BEHIND];
    hflip_o   = attr[ATTR_HFLIP];
  end
endmodule

// File: rtl/spl_scan_ctrl.sv
module spl_scan_ctrl #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [IDX_W-1:0] rot_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o,
  output logic             done_o
);
  logic [IDX_W-1:0] step;

  assign last_o = busy_o && (step == IDX_W'(ENTRIES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      idx_o  <= '0;
      step   <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= last_o && !start_i;
      if (start_i) begin
        busy_o <= 1'b1;
        idx_o  <= rot_i;
        step   <= '0;
      end else if (busy_o) begin
        idx_o <= (idx_o == IDX_W'(ENTRIES - 1)) ? '0 : idx_o + 1'b1;
        step  <= step + 1'b1;
        if (last_o) busy_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spl_slot_store.sv
module spl_slot_store #(
  parameter int SLOTS = 8,
  parameter int ROW_W = 3,
  parameter int CNT_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear_i,
  input  logic                   hit_i,
  input  logic [ROW_W-1:0]       row_i,
  input  logic [7:0]             tile_i,
  input  logic [7:0]             x_i,
  input  logic [1:0]             pal_i,
  input  logic                   behind_i,
  input  logic                   hflip_i,
  output logic [SLOTS*ROW_W-1:0] row_o,
  output logic [SLOTS*8-1:0]     tile_o,
  output logic [SLOTS*8-1:0]     x_o,
  output logic [SLOTS*2-1:0]     pal_o,
  output logic [SLOTS-1:0]       behind_o,
  output logic [SLOTS-1:0]       hflip_o,
  output logic [CNT_W-1:0]       count_o,
  output logic                   overflow_o,
  output logic                   store_ev_o,
  output logic                   ovf_ev_o
);
  logic full;
  assign full       = (count_o == CNT_W'(SLOTS));
  assign store_ev_o = hit_i && !full && !clear_i;
  assign ovf_ev_o   = hit_i && full && !clear_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o    <= '0;
      overflow_o <= 1'b0;
    end else if (clear_i) begin
      count_o    <= '0;
      overflow_o <= 1'b0;
    end else begin
      if (store_ev_o) count_o <= count_o + 1'b1;
      if (ovf_ev_o) overflow_o <= 1'b1;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_o[s*ROW_W +: ROW_W] <= '0;
        tile_o[s*8 +: 8]        <= '0;
        x_o[s*8 +: 8]           <= '0;
        pal_o[s*2 +: 2]         <= '0;
        behind_o[s]             <= 1'b0;
        hflip_o[s]              <= 1'b0;
      end else if (store_ev_o && count_o == CNT_W'(s)) begin
        row_o[s*ROW_W +: ROW_W] <= row_i;
        tile_o[s*8 +: 8]        <= tile_i;
        x_o[s*8 +: 8]           <= x_i;
        pal_o[s*2 +: 2]         <= pal_i;
        behind_o[s]             <= behind_i;
        hflip_o[s]              <= hflip_i;
      end
    end
  end
endmodule

// File: rtl/sprite_line_picker.sv
module sprite_line_picker
  import spl_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int SLOTS   = 8,
  parameter int SPR_H   = 8,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int CNT_W  = $clog2(SLOTS + 1),
  localparam int ROW_W  = $clog2(SPR_H)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [7:0]             line_i,
  input  logic [IDX_W-1:0]       rot_i,
  output logic [IDX_W-1:0]       oam_addr_o,
  input  logic [WORD_W-1:0]      oam_data_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [CNT_W-1:0]       found_o,
  output logic                   overflow_o,
  output logic [SLOTS*ROW_W-1:0] row_o,
  output logic [SLOTS*8-1:0]     tile_o,
  output logic [SLOTS*8-1:0]     x_o,
  output logic [SLOTS*2-1:0]     pal_o,
  output logic [SLOTS-1:0]       behind_o,
  output logic [SLOTS-1:0]       hflip_o
);
  logic             in_band, hit_ev, store_ev, ovf_ev, last_ev;
  logic [ROW_W-1:0] e_row;
  logic [7:0]       e_tile, e_x;
  logic [1:0]       e_pal;
  logic             e_behind, e_hflip;

  spl_scan_ctrl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rot_i(rot_i),
    .busy_o(busy_o), .idx_o(oam_addr_o), .last_o(last_ev), .done_o(done_o)
  );

  spl_entry_eval #(.SPR_H(SPR_H), .ROW_W(ROW_W)) u_eval (
    .line_i(line_i), .word_i(oam_data_i), .in_band_o(in_band),
    .row_o(e_row), .tile_o(e_tile), .x_o(e_x), .pal_o(e_pal),
    .behind_o(e_behind), .hflip_o(e_hflip)
  );

  assign hit_ev = busy_o && in_band;

  spl_slot_store #(.SLOTS(SLOTS), .ROW_W(ROW_W), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clear_i(start_i), .hit_i(hit_ev),
    .row_i(e_row), .tile_i(e_tile), .x_i(e_x), .pal_i(e_pal),
    .behind_i(e_behind), .hflip_i(e_hflip),
    .row_o(row_o), .tile_o(tile_o), .x_o(x_o), .pal_o(pal_o),
    .behind_o(behind_o), .hflip_o(hflip_o),
    .count_o(found_o), .overflow_o(overflow_o),
    .store_ev_o(store_ev), .ovf_ev_o(ovf_ev)
  );
endmodule

// File: rtl/spl_checker.sv
module spl_checker #(
  parameter int ENTRIES = 64,
  parameter int SLOTS   = 8,
  parameter int IDX_W   = 6,
  parameter int CNT_W   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [IDX_W-1:0] oam_addr_o,
  input logic [CNT_W-1:0] found_o,
  input logic             overflow_o,
  input logic             store_ev,
  input logic             ovf_ev,
  input logic             last_ev
);
  assert_count_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    found_o <= CNT_W'(SLOTS));

  assert_store_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    store_ev |=> found_o == $past(found_o) + 1'b1);

  assert_ovf_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |-> found_o == CNT_W'(SLOTS));

  assert_ovf_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow_o && !start_i) |=> overflow_o);

  assert_start_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!overflow_o && found_o == '0 && busy_o));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_last_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (last_ev && !start_i) |=> (done_o && !busy_o));

  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(found_o) && $stable(overflow_o) && !busy_o));

  assert_addr_walk_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !start_i && !last_ev) |=>
      oam_addr_o == (($past(oam_addr_o) == IDX_W'(ENTRIES - 1)) ? '0 : $past(oam_addr_o) + 1'b1));
endmodule

bind sprite_line_picker spl_checker #(
  .ENTRIES(ENTRIES), .SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .oam_addr_o(oam_addr_o), .found_o(found_o),
  .overflow_o(overflow_o), .store_ev(store_ev), .ovf_ev(ovf_ev),
  .last_ev(last_ev)
);

// File: tb/sprite_line_picker_test.sv
module sprite_line_picker_test;
  localparam int N = 64;
  localparam int S = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, start;
  logic [7:0]  line;
  logic [5:0]  rot;
  logic [31:0] mem [N];
  wire  [5:0]  addr;
  wire  [31:0] data = mem[addr];
  wire         busy, done, ovf;
  wire  [3:0]  found;
  wire  [23:0] row_f;
  wire  [63:0] tile_f, x_f;
  wire  [15:0] pal_f;
  wire  [7:0]  beh_f, hfl_f;

  sprite_line_picker uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .line_i(line), .rot_i(rot),
    .oam_addr_o(addr), .oam_data_i(data), .busy_o(busy), .done_o(done),
    .found_o(found), .overflow_o(ovf), .row_o(row_f), .tile_o(tile_f),
    .x_o(x_f), .pal_o(pal_f), .behind_o(beh_f), .hflip_o(hfl_f)
  );

  int checks = 0, fails = 0;
  int exp_n; bit exp_ovf;
  int exp_row[S], exp_tile[S], exp_x[S], exp_pal[S], exp_beh[S], exp_hfl[S];
  bit ovf_before_done;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int y, int tile, int attr, int x);
    return {x[7:0], attr[7:0], tile[7:0], y[7:0]};
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < N; i++) mem[i] = mk(8'hF0, i, 0, i);
  endtask

  // independent reference of the selection rules
  task automatic model(int l, int r);
    exp_n = 0; exp_ovf = 0;
    for (int k = 0; k < N; k++) begin
      int idx = (r + k) % N;
      int y = mem[idx][7:0];
      int a = mem[idx][23:16];
      int d = l - y;
      if (d >= 0 && d <= 7) begin
        if (exp_n == S) exp_ovf = 1;
        else begin
          exp_row[exp_n]  = a[7] ? 7 - d : d;
          exp_tile[exp_n] = mem[idx][15:8];
          exp_x[exp_n]    = mem[idx][31:24];
          exp_pal[exp_n]  = a & 3;
          exp_beh[exp_n]  = a[5];
          exp_hfl[exp_n]  = a[6];
          exp_n++;
        end
      end
    end
  endtask

  task automatic compare(string tag);
    chk(found == 4'(exp_n), {tag, " R4 count"}, found, exp_n);
    chk(ovf == exp_ovf, {tag, " R3 overflow"}, ovf, exp_ovf);
    for (int i = 0; i < exp_n; i++) begin
      chk(row_f[i*3 +: 3] == 3'(exp_row[i]), {tag, " R5 row"}, row_f[i*3 +: 3], exp_row[i]);
      chk(tile_f[i*8 +: 8] == 8'(exp_tile[i]), {tag, " R6 tile"}, tile_f[i*8 +: 8], exp_tile[i]);
      chk(x_f[i*8 +: 8] == 8'(exp_x[i]), {tag, " R6 x"}, x_f[i*8 +: 8], exp_x[i]);
      chk(pal_f[i*2 +: 2] == 2'(exp_pal[i]), {tag, " R6 palette"}, pal_f[i*2 +: 2], exp_pal[i]);
      chk(beh_f[i] == 1'(exp_beh[i]), {tag, " R6 behind"}, beh_f[i], exp_beh[i]);
      chk(hfl_f[i] == 1'(exp_hfl[i]), {tag, " R6 hflip"}, hfl_f[i], exp_hfl[i]);
    end
  endtask

  task automatic run_scan(int l, int r, string tag);
    bit addr_ok = 1, busy_ok = 1;
    int bad_addr = 0, want_addr = 0;
    model(l, r);
    @(negedge clk);
    line = 8'(l); rot = 6'(r); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (k > 0) @(negedge clk);
      if (addr_ok && addr != 6'((r + k) % N)) begin
        addr_ok = 0; bad_addr = addr; want_addr = (r + k) % N;
      end
      if (!busy || done) busy_ok = 0;
      if (k == N - 1) ovf_before_done = ovf;
    end
    chk(addr_ok, {tag, " R7 address walk"}, bad_addr, want_addr);
    chk(busy_ok, {tag, " R8 busy during scan"}, busy_ok, 1);
    @(negedge clk);
    chk(done == 1'b1, {tag, " R8 done after 64"}, done, 1);
    chk(busy == 1'b0, {tag, " R8 busy low at done"}, busy, 0);
    compare(tag);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R8 done one cycle"}, done, 0);
  endtask

  task automatic t_reset();
    chk(found == 0, "R1 count", found, 0);
    chk(ovf == 0, "R1 overflow", ovf, 0);
    chk(done == 0, "R1 done", done, 0);
    chk(busy == 0, "R1 busy", busy, 0);
  endtask

  task automatic t_basic();
    clear_mem();
    mem[3]  = mk(45, 11, 8'h02, 20);
    mem[17] = mk(50, 12, 8'hE1, 30);
    mem[40] = mk(43, 13, 8'h80, 40);
    mem[41] = mk(42, 14, 8'h00, 50);   // offset 8: miss (R2)
    mem[42] = mk(51, 15, 8'h00, 60);   // y above line: miss (R2)
    mem[60] = mk(46, 16, 8'h40, 255);
    run_scan(50, 0, "basic R2");
    chk(found == 4, "basic R2 exact hits", found, 4);
    chk(row_f[5:3] == 3'd7, "basic R5 vflip row", row_f[5:3], 7);
  endtask

  task automatic t_low_line();
    clear_mem();
    mem[8] = mk(250, 21, 0, 9);        // wraps negative: miss (R2)
    mem[9] = mk(0, 22, 3, 10);
    run_scan(3, 0, "lowline R2");
    chk(found == 1 && tile_f[7:0] == 22, "lowline R2 only y0", tile_f[7:0], 22);
  endtask

  task automatic t_overflow();
    clear_mem();
    for (int i = 0; i < 10; i++) mem[i*5] = mk(100 - (i % 8), 30 + i, i, i * 10);
    run_scan(100, 0, "ovf R3");
    chk(tile_f[63:56] == 37, "ovf R4 eighth slot", tile_f[63:56], 37);
  endtask

  task automatic t_rotate();
    run_scan(100, 30, "rot R7");
    chk(tile_f[7:0] == 36, "rot R7 first slot", tile_f[7:0], 36);
    chk(tile_f[39:32] == 30, "rot R7 wrapped slot", tile_f[39:32], 30);
  endtask

  task automatic t_last_cycle();
    clear_mem();
    for (int i = 10; i < 18; i++) mem[i] = mk(120, i, 0, i);
    mem[9] = mk(117, 99, 0, 1);
    run_scan(120, 10, "lastcyc R3");
    chk(ovf_before_done == 0, "lastcyc R3 not early", ovf_before_done, 0);
  endtask

  task automatic t_clear();
    clear_mem();
    mem[33] = mk(118, 44, 8'h21, 77);
    run_scan(120, 0, "clear R3");
  endtask

  task automatic t_stable();
    logic [3:0] f0 = found; logic o0 = ovf; logic [63:0] t0 = tile_f;
    logic [23:0] r0 = row_f;
    for (int i = 0; i < N; i++) mem[i] = mk(5, 200, 8'hFF, 1);
    line = 8'd7;
    for (int c = 0; c < 20; c++) @(negedge clk);
    chk(found == f0, "R9 count held", found, f0);
    chk(ovf == o0, "R9 overflow held", ovf, o0);
    chk(tile_f == t0, "R9 tiles held", tile_f[7:0], t0[7:0]);
    chk(row_f == r0, "R9 rows held", row_f[2:0], r0[2:0]);
    chk(done == 0 && busy == 0, "R9 stays idle", busy, 0);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; line = '0; rot = '0;
    clear_mem();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_low_line();
    t_overflow();
    t_rotate();
    t_last_cycle();
    t_clear();
    t_stable();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule